// File: doc/BRIEF.md
# Control-Transfer Sequencer

This unit steps the program counter of a small byte-wide processor. It fetches instruction bytes through a request/acknowledge handshake and classifies each opcode. When an instruction carries a two-byte target, it gathers both bytes. It then decides the next program counter from a three-bit condition tested against four external status flags.

The unit handles the following instruction kinds:
- plain jumps and conditional jumps;
- calls and conditional calls;
- returns and conditional returns;
- one-byte restarts to fixed vectors;
- halt codes.

Return addresses live in a small internal stack that wraps silently.

Every other opcode counts as a one-byte instruction that only advances the counter. The data path beside the sequencer handles those opcodes. A one-cycle `step_done` pulse marks each finished instruction, and `pc` already holds its successor when the pulse is seen.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is active, `pc` is 0, `halted` and `step_done` are 0, `fetch_req` is 1 and `fetch_addr` is 0. The internal stack is empty.
- R2: An opcode outside the classes listed in R3 to R8 occupies one byte. It moves `pc` to the next byte, for example 0x80, 0xC1, or 0x04 with no operand taken.
- R3: Opcode 01_xxx_100 is an unconditional jump. It reads a low target byte and then a high target byte. Only bits 5:0 of the high byte are used, forming the 14-bit target {high[5:0], low}. The x bits are don't-care.
- R4: Opcode 01_ccc_000 is a conditional jump. ccc[1:0] selects `flags` bit 0 (carry), 1 (zero), 2 (sign) or 3 (parity). The condition holds when that bit equals ccc[2]. When it fails, both target bytes are still consumed and `pc` becomes the address after the third byte.
- R5: Opcode 01_xxx_110 is a call and 01_ccc_010 is a conditional call. A taken call pushes the address after its third byte and jumps to the target. A call not taken pushes nothing and continues after the third byte.
- R6: Opcode 00_xxx_111 is a return and 00_ccc_011 is a conditional return. A taken return pops `pc` from the stack. A conditional return not taken moves to the next byte and leaves the stack untouched.
- R7: Opcode 00_nnn_101 is a restart. It pushes the address of the next byte and sets `pc` to nnn×8.
- R8: Opcodes 0x00, 0x01 and 0xFF halt the unit. `halted` rises, `fetch_req` drops and `pc` stays on the halt byte until reset.
- R9: The stack holds 7 entries. An eighth push overwrites the oldest entry. Pops walk back through the entries cyclically, so the eighth pop after eight pushes again returns the last pushed address.
- R10: A byte is consumed only in a cycle with both `fetch_req` and `fetch_ack` high. While `fetch_ack` is low, the state and `pc` hold and `step_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flags | input | 4 | Status flags: 0 carry, 1 zero, 2 sign, 3 parity |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 14 | Address of the byte being fetched |
| fetch_ack | input | 1 | Fetch acknowledge; `fetch_data` valid in the same cycle |
| fetch_data | input | 8 | Fetched byte |
| pc | output | 14 | Program counter |
| step_done | output | 1 | One-cycle pulse when an instruction finishes |
| halted | output | 1 | High after a halt opcode until reset |

## Verification
The hardest state to reach from the ports is stack wrap. It needs eight nested pushes with no return between them, followed by eight returns whose addresses prove which entry was overwritten. A dedicated program chains seven restarts through distinct vectors and then one call. Return opcodes sit at each pushed address, so every pop lands on the next return and the program-counter trace exposes the wrap order.

The main program is also run a second time with a periodic acknowledge stall. This shows that operand collection and condition evaluation survive wait cycles.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [1:0] {
    ST_OPC,
    ST_ALO,
    ST_AHI,
    ST_STOP
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_PLAIN,
    OP_HALT,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_RST
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       cond;
    logic [2:0] sel;
  } op_info_t;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [7:0] opc,
  output op_info_t   info
);

  always_comb begin
    info.kind = OP_PLAIN;
    info.cond = 1'b0;
    info.sel  = opc[5:3];
    if (opc[7:1] == 7'b0 || opc == 8'hFF) begin
      info.kind = OP_HALT;
    end else if (opc[7:6] == 2'b01) begin
      case (opc[2:0])
        3'b000:  begin info.kind = OP_JUMP; info.cond = 1'b1; end
        3'b010:  begin info.kind = OP_CALL; info.cond = 1'b1; end
        3'b100:  info.kind = OP_JUMP;
        3'b110:  info.kind = OP_CALL;
        default: info.kind = OP_PLAIN;
      endcase
    end else if (opc[7:6] == 2'b00) begin
      case (opc[2:0])
        3'b011:  begin info.kind = OP_RET; info.cond = 1'b1; end
        3'b111:  info.kind = OP_RET;
        3'b101:  info.kind = OP_RST;
        default: info.kind = OP_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/flow_cond.sv
module flow_cond (
  input  logic [3:0] flags,
  input  logic [2:0] sel,
  output logic       met
);

  // sel[1:0] picks the flag, sel[2] is the value it must have
  always_comb met = (flags[sel[1:0]] == sel[2]);

endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int DEPTH = 7,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);

  localparam int SP_W = $clog2(DEPTH);

  logic [SP_W-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic [W-1:0]    ent_q [DEPTH];

  always_comb begin
    sp_inc = (sp_q == SP_W'(DEPTH - 1)) ? '0 : sp_q + 1'b1;
    sp_dec = (sp_q == '0) ? SP_W'(DEPTH - 1) : sp_q - 1'b1;
    sp_d   = sp_q;
    if (push)     sp_d = sp_inc;
    else if (pop) sp_d = sp_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sp_q <= '0;
    else if (push || pop)  sp_q <= sp_d;
  end

  // entry storage carries no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && sp_q == SP_W'(g)) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[sp_dec];

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sp_q) < DEPTH); // R9
  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R9
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && sp_q == SP_W'(DEPTH - 1)) |=> sp_q == '0); // R9

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_pkg::*;
#(
  parameter int PC_W        = 14,
  parameter int STACK_DEPTH = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      flags,
  output logic            fetch_req,
  output logic [PC_W-1:0] fetch_addr,
  input  logic            fetch_ack,
  input  logic [7:0]      fetch_data,
  output logic [PC_W-1:0] pc,
  output logic            step_done,
  output logic            halted
);

  localparam int HI_W = PC_W - 8;

  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  seq_state_e      state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, target;
  logic [7:0]      lo_q, lo_d;
  op_info_t        opk_q, opk_d, dec;
  logic            done_q, done_d;
  logic            take, met, push, pop;
  logic [2:0]      sel;
  logic [PC_W-1:0] stk_rdata;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  flow_decode u_dec (.opc(fetch_data), .info(dec));

  assign sel = (state_q == ST_OPC) ? dec.sel : opk_q.sel;
  flow_cond u_cond (.flags(flags), .sel(sel), .met(met));

  flow_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_ni), .push(push), .pop(pop),
    .wdata(pc_inc), .rdata(stk_rdata)
  );

  assign fetch_req  = (state_q != ST_STOP);
  assign fetch_addr = pc_q;
  assign take       = fetch_req && fetch_ack;
  assign pc_inc     = pc_q + 1'b1;
  assign target     = {fetch_data[HI_W-1:0], lo_q};

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    lo_d    = lo_q;
    opk_d   = opk_q;
    done_d  = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    if (take) begin
      case (state_q)
        ST_OPC: begin
          case (dec.kind)
            OP_HALT: begin
              state_d = ST_STOP;
              done_d  = 1'b1;
            end
            OP_JUMP, OP_CALL: begin
              opk_d   = dec;
              pc_d    = pc_inc;
              state_d = ST_ALO;
            end
            OP_RET: begin
              done_d = 1'b1;
              if (!dec.cond || met) begin
                pop  = 1'b1;
                pc_d = stk_rdata;
              end else begin
                pc_d = pc_inc;
              end
            end
            OP_RST: begin
              push      = 1'b1;
              pc_d      = '0;
              pc_d[5:3] = dec.sel;
              done_d    = 1'b1;
            end
            default: begin
              pc_d   = pc_inc;
              done_d = 1'b1;
            end
          endcase
        end
        ST_ALO: begin
          lo_d    = fetch_data;
          pc_d    = pc_inc;
          state_d = ST_AHI;
        end
        ST_AHI: begin
          state_d = ST_OPC;
          done_d  = 1'b1;
          if (!opk_q.cond || met) begin
            pc_d = target;
            push = (opk_q.kind == OP_CALL);
          end else begin
            pc_d = pc_inc;
          end
        end
        default: state_d = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      pc_q    <= '0;
      lo_q    <= '0;
      opk_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (take) begin
        state_q <= state_d;
        pc_q    <= pc_d;
        lo_q    <= lo_d;
        opk_q   <= opk_d;
      end
    end
  end

  assign pc        = pc_q;
  assign step_done = done_q;
  assign halted    = (state_q == ST_STOP);

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> halted && $stable(pc)); // R8
  AST_RST_ALIGN: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_OPC && take && dec.kind == OP_RST) |=> pc[2:0] == 3'b000); // R7
  AST_OPERAND_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_ALO && take) |=> pc == PC_W'($past(pc) + 1'b1)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_req && !fetch_ack) |=> $stable(pc) && !step_done); // R10

endmodule

// File: tb/sim_flow_sequencer.sv
module sim_flow_sequencer;

  localparam int WD_LIMIT = 150000;
  localparam int NSTEP    = 37;

  // entry = {requirement number, flags applied before the step, expected pc}
  localparam logic [21:0] TRACE [NSTEP] = '{
    // program A: indices 0..16
    {4'd2, 4'h0, 14'h0001},  // R2 plain
    {4'd3, 4'h0, 14'h0010},  // R3 jump
    {4'd4, 4'h1, 14'h0013},  // R4 false, carry set
    {4'd4, 4'h1, 14'h0020},  // R4 true
    {4'd5, 4'h0, 14'h0030},  // R5 call
    {4'd5, 4'h2, 14'h0033},  // R5 false call
    {4'd5, 4'h2, 14'h0050},  // R5 true call
    {4'd6, 4'h8, 14'h0051},  // R6 false return
    {4'd6, 4'h8, 14'h0036},  // R6 true return
    {4'd7, 4'h0, 14'h0038},  // R7 restart 7
    {4'd6, 4'h0, 14'h0037},  // R6 return
    {4'd6, 4'h0, 14'h0023},  // R6 return, x bits set
    {4'd3, 4'h0, 14'h3F40},  // R3 high byte masked
    {4'd2, 4'h0, 14'h3F41},  // R2
    {4'd7, 4'h0, 14'h0008},  // R7 restart 1
    {4'd6, 4'h0, 14'h3F42},  // R6
    {4'd8, 4'h0, 14'h3F42},  // R8 halt 0xFF
    // program B: indices 17..32
    {4'd7, 4'h0, 14'h0008}, {4'd7, 4'h0, 14'h0010}, {4'd7, 4'h0, 14'h0018},
    {4'd7, 4'h0, 14'h0020}, {4'd7, 4'h0, 14'h0028}, {4'd7, 4'h0, 14'h0030},
    {4'd7, 4'h0, 14'h0038},
    {4'd5, 4'h0, 14'h0080},  // R5 eighth push
    {4'd9, 4'h0, 14'h003B}, {4'd9, 4'h0, 14'h0031}, {4'd9, 4'h0, 14'h0029},
    {4'd9, 4'h0, 14'h0021}, {4'd9, 4'h0, 14'h0019}, {4'd9, 4'h0, 14'h0011},
    {4'd9, 4'h0, 14'h0009},
    {4'd9, 4'h0, 14'h003B},  // R9 wrapped pop
    // program C: indices 33..36
    {4'd2, 4'h0, 14'h0001},  // R2 0x04 one byte
    {4'd4, 4'h4, 14'h0004},  // R4 sign false
    {4'd3, 4'h4, 14'h000A},  // R3 hi bits 7:6 dropped
    {4'd8, 4'h0, 14'h000A}   // R8 halt 0x01
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  flags = 4'h0;
  logic        fetch_req, fetch_ack, step_done, halted;
  logic [13:0] fetch_addr, pc;
  logic [7:0]  fetch_data;
  logic [7:0]  mem [256];
  logic        stall_en = 1'b0;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  assign fetch_data = mem[fetch_addr[7:0]];
  assign fetch_ack  = !stall_en || (cyc[1:0] != 2'b01);

  flow_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .flags(flags),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .pc(pc), .step_done(step_done), .halted(halted)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R10: actual cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic load_a();
    clear_mem();
    mem[8'h00] = 8'h80;
    mem[8'h01] = 8'h44; mem[8'h02] = 8'h10; mem[8'h03] = 8'h00;
    mem[8'h08] = 8'h07;
    mem[8'h10] = 8'h40; mem[8'h11] = 8'h30; mem[8'h12] = 8'h00;
    mem[8'h13] = 8'h60; mem[8'h14] = 8'h20; mem[8'h15] = 8'h00;
    mem[8'h20] = 8'h46; mem[8'h21] = 8'h30; mem[8'h22] = 8'h00;
    mem[8'h23] = 8'h5C; mem[8'h24] = 8'h40; mem[8'h25] = 8'hFF;
    mem[8'h30] = 8'h4A; mem[8'h31] = 8'h50; mem[8'h32] = 8'h00;
    mem[8'h33] = 8'h6A; mem[8'h34] = 8'h50; mem[8'h35] = 8'h00;
    mem[8'h36] = 8'h3D; mem[8'h37] = 8'h3F; mem[8'h38] = 8'h07;
    mem[8'h40] = 8'hC1; mem[8'h41] = 8'h0D; mem[8'h42] = 8'hFF;
    mem[8'h50] = 8'h1B; mem[8'h51] = 8'h3B;
  endtask

  task automatic load_b();
    clear_mem();
    mem[8'h00] = 8'h0D; mem[8'h08] = 8'h15; mem[8'h10] = 8'h1D;
    mem[8'h18] = 8'h25; mem[8'h20] = 8'h2D; mem[8'h28] = 8'h35;
    mem[8'h30] = 8'h3D;
    mem[8'h38] = 8'h46; mem[8'h39] = 8'h80; mem[8'h3A] = 8'h00;
    mem[8'h80] = 8'h07; mem[8'h3B] = 8'h07; mem[8'h31] = 8'h07;
    mem[8'h29] = 8'h07; mem[8'h21] = 8'h07; mem[8'h19] = 8'h07;
    mem[8'h11] = 8'h07; mem[8'h09] = 8'h07;
  endtask

  task automatic load_c();
    clear_mem();
    mem[8'h00] = 8'h04;
    mem[8'h01] = 8'h50; mem[8'h02] = 8'h77; mem[8'h03] = 8'h00;
    mem[8'h04] = 8'h70; mem[8'h05] = 8'h0A; mem[8'h06] = 8'hC0;
    mem[8'h0A] = 8'h01;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_trace(input int first, input int last);
    for (int i = first; i <= last; i++) begin
      bit seen;
      seen  = 1'b0;
      flags = TRACE[i][17:14];
      if (i == first) rst_n = 1'b1;
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        if (step_done) begin
          seen = 1'b1;
          break;
        end
      end
      checks = checks + 1;
      if (!seen) begin
        errors = errors + 1;
        $display("FAIL R%0d step %0d: actual no step_done expected pulse", TRACE[i][21:18], i);
      end else if (pc != TRACE[i][13:0]) begin
        errors = errors + 1;
        $display("FAIL R%0d step %0d: pc actual %h expected %h",
                 TRACE[i][21:18], i, pc, TRACE[i][13:0]);
      end
    end
  endtask

  task automatic check_stopped(input int exp_pc);
    check("R8 halted", int'(halted), 1);
    check("R8 fetch_req", int'(fetch_req), 0);
    repeat (10) @(negedge clk);
    check("R8 pc held", int'(pc), exp_pc);
    check("R8 still halted", int'(halted), 1);
  endtask

  initial begin
    load_a();
    hold_reset();
    // R1: reset state
    check("R1 pc", int'(pc), 0);
    check("R1 halted", int'(halted), 0);
    check("R1 step_done", int'(step_done), 0);
    check("R1 fetch_req", int'(fetch_req), 1);
    check("R1 fetch_addr", int'(fetch_addr), 0);

    // main table walk, no stalls
    run_trace(0, 16);
    check_stopped(14'h3F42);

    // same program with acknowledge stalls: R10
    stall_en = 1'b1;
    hold_reset();
    check("R1 pc after halt", int'(pc), 0);
    check("R1 halted cleared", int'(halted), 0);
    run_trace(0, 16);
    check_stopped(14'h3F42);
    stall_en = 1'b0;

    // stack wrap: R9
    load_b();
    hold_reset();
    run_trace(17, 32);

    // sign condition, masked high bits, halt 0x01
    load_c();
    hold_reset();
    run_trace(33, 36);
    check_stopped(14'h000A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule